// File: doc/BRIEF.md
# Binary/Decimal Add-Subtract Unit

This is a purely combinational arithmetic unit for an 8-bit accumulator datapath. It adds with carry or subtracts with borrow, either as plain binary numbers or as packed two-digit BCD. The carry input acts as an inverted borrow during subtraction. Besides the result, it produces carry, overflow, zero and negative flags.

In decimal mode the flags follow what the processor actually does, not idealised BCD rules. For a decimal add, the zero flag is taken from the uncorrected binary sum. The negative and overflow flags are taken from the upper digit after the carry from the lower digit has been added, but before that upper digit is corrected. The carry comes from the corrected upper digit. For a decimal subtract, every flag comes from the binary difference, and only the stored result uses the corrected digits.

The digit correction is built as a chain of identical digit cells, so the digit count is a parameter. A binary core runs in parallel with the chain, and the top selects between them.

Top module: `addsub_unit`

## Requirements
- R1: Binary add (decimal_i=0, subtract_i=0): {carry_o, sum_o} equals a_i + b_i + carry_i as a 9-bit value.
- R2: Binary add: ovf_o is 1 exactly when a_i and b_i have equal bit 7 and sum_o bit 7 differs from a_i bit 7.
- R3: Subtract, in either mode: carry_o is 1 exactly when a_i - b_i - (1 - carry_i) is not negative.
- R4: Subtract, in either mode: ovf_o is 1 exactly when a_i and b_i differ in bit 7 and bit 7 of the 8-bit binary difference differs from a_i bit 7.
- R5: Binary mode: zero_o is 1 exactly when sum_o is 0x00, and neg_o equals sum_o bit 7.
- R6: Decimal add result, low digit: L = a[3:0] + b[3:0] + carry_i, plus 6 if L > 9; sum_o[3:0] = L[3:0]. High digit: H = a[7:4] + b[7:4] + (L > 15), plus 6 if H > 9; sum_o[7:4] = H[3:0].
- R7: Decimal add: zero_o is 1 exactly when the low 8 bits of the binary sum a_i + b_i + carry_i are zero.
- R8: Decimal add: neg_o is bit 3 of H before its +6 correction; ovf_o is 1 when that bit differs from a_i bit 7 and a_i and b_i have equal bit 7.
- R9: Decimal add: carry_o is 1 exactly when the corrected H exceeds 15 (for example 0x99 + 0x01 gives 0x00 with carry set).
- R10: Decimal subtract result: L = a[3:0] - b[3:0] - (1 - carry_i); if L is negative, 6 is taken from L and 1 from the high digit. H = a[7:4] - b[7:4] - that borrow, minus 6 if negative; sum_o holds the low 4 bits of each digit (0x00 - 0x01 gives 0x99).
- R11: Decimal subtract: zero_o and neg_o come from the 8-bit binary difference, not from sum_o.
- R12: Binary subtract: sum_o equals a_i - b_i - (1 - carry_i) modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry in (an inverted borrow when subtracting) |
| decimal_i | input | 1 | 1 selects packed BCD mode |
| subtract_i | input | 1 | 1 selects subtract, 0 selects add |
| sum_o | output | 8 | Result |
| carry_o | output | 1 | Carry out (1 means no borrow when subtracting) |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |

## Verification
The hardest cases to reach are decimal operations on non-BCD operands. These include digits A through F, and upper digits whose raw sum passes 15. Only in such cases do the uncorrected-digit N and V flags and the double correction differ from the idealised behaviour. The stimulus sweeps every combination of mode, direction, carry and both operands, so all of these cases are applied. Each output is compared with an integer model built from the requirements. A few hand-worked vectors, such as 0x99 + 0x01 and 0x00 - 0x01 in decimal mode, are run first.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic zero;
    logic neg;
  } alu_flags_t;
endpackage

// File: rtl/addsub_bin_core.sv
module addsub_bin_core #(
  parameter int W = 8
) (
  input  logic                   [W-1:0] a_i,
  input  logic                   [W-1:0] b_i,
  input  logic                           carry_i,
  input  logic                           subtract_i,
  output logic                   [W-1:0] res_o,
  output addsub_pkg::alu_flags_t         flags_o
);
  logic [W:0] wide;
  logic       same_sign;
  logic       sign_moved;

  always_comb begin
    if (subtract_i)
      wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, ~carry_i};
    else
      wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, carry_i};
    res_o         = wide[W-1:0];
    same_sign     = ~(a_i[W-1] ^ b_i[W-1]);
    sign_moved    = a_i[W-1] ^ wide[W-1];
    flags_o.carry = subtract_i ? ~wide[W] : wide[W];
    flags_o.ovf   = subtract_i ? (~same_sign & sign_moved) : (same_sign & sign_moved);
    flags_o.zero  = (wide[W-1:0] == '0);
    flags_o.neg   = wide[W-1];
  end
endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       link_i,
  input  logic       subtract_i,
  output logic [3:0] digit_o,
  output logic       link_o,
  output logic       raw_bit3_o
);
  logic [5:0] raw_add;
  logic [5:0] fix_add;
  logic [5:0] raw_sub;
  logic [3:0] fix_sub;

  always_comb begin
    raw_add = {2'b00, a_i} + {2'b00, b_i} + {5'b0, link_i};
    fix_add = (raw_add > 6'd9) ? raw_add + 6'd6 : raw_add;
    raw_sub = {2'b00, a_i} - {2'b00, b_i} - {5'b0, link_i};
    fix_sub = raw_sub[4] ? raw_sub[3:0] - 4'd6 : raw_sub[3:0];
    if (subtract_i) begin
      digit_o = fix_sub;
      link_o  = raw_sub[4];
    end else begin
      digit_o = fix_add[3:0];
      link_o  = |fix_add[5:4];
    end
    raw_bit3_o = raw_add[3];
  end
endmodule

// File: rtl/bcd_adjust_chain.sv
module bcd_adjust_chain #(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * addsub_pkg::DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         subtract_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         top_raw_bit3_o
);
  localparam int DW = addsub_pkg::DIGIT_W;

  logic [DIGITS:0]   link;
  logic [DIGITS-1:0] raw_bit3;

  assign link[0] = subtract_i ? ~carry_i : carry_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_cell u_cell (
      .a_i       (a_i[g*DW +: DW]),
      .b_i       (b_i[g*DW +: DW]),
      .link_i    (link[g]),
      .subtract_i(subtract_i),
      .digit_o   (res_o[g*DW +: DW]),
      .link_o    (link[g+1]),
      .raw_bit3_o(raw_bit3[g])
    );
  end

  assign carry_o        = subtract_i ? ~link[DIGITS] : link[DIGITS];
  assign top_raw_bit3_o = raw_bit3[DIGITS-1];
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * addsub_pkg::DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         decimal_i,
  input  logic         subtract_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         zero_o,
  output logic         neg_o
);
  logic [W-1:0]           bin_res;
  addsub_pkg::alu_flags_t bin_flags;
  logic [W-1:0]           dec_res;
  logic                   dec_carry;
  logic                   dec_top_bit3;

  addsub_bin_core #(.W(W)) u_bin (
    .a_i       (a_i),
    .b_i       (b_i),
    .carry_i   (carry_i),
    .subtract_i(subtract_i),
    .res_o     (bin_res),
    .flags_o   (bin_flags)
  );

  bcd_adjust_chain #(.DIGITS(DIGITS)) u_dec (
    .a_i           (a_i),
    .b_i           (b_i),
    .carry_i       (carry_i),
    .subtract_i    (subtract_i),
    .res_o         (dec_res),
    .carry_o       (dec_carry),
    .top_raw_bit3_o(dec_top_bit3)
  );

  always_comb begin
    sum_o   = decimal_i ? dec_res : bin_res;
    carry_o = bin_flags.carry;
    ovf_o   = bin_flags.ovf;
    zero_o  = bin_flags.zero;
    neg_o   = bin_flags.neg;
    if (decimal_i && !subtract_i) begin
      carry_o = dec_carry;
      neg_o   = dec_top_bit3;
      ovf_o   = (dec_top_bit3 ^ a_i[W-1]) & ~(a_i[W-1] ^ b_i[W-1]);
    end
  end
endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         carry_i,
  input logic         decimal_i,
  input logic         subtract_i,
  input logic [W-1:0] sum_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         zero_o,
  input logic         neg_o
);
  logic [W:0] plain_sum;
  logic [W:0] plain_diff;
  logic [W:0] need;

  always_comb begin
    plain_sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, carry_i};
    plain_diff = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, ~carry_i};
    need       = {1'b0, b_i} + {{W{1'b0}}, ~carry_i};
    if (!decimal_i && !subtract_i)
      p_bin_add_r1: assert ({carry_o, sum_o} == plain_sum)
        else $error("binary add result/carry mismatch");
    if (!decimal_i && subtract_i)
      p_bin_sub_r12: assert (sum_o == plain_diff[W-1:0])
        else $error("binary subtract result mismatch");
    if (subtract_i)
      p_no_borrow_r3: assert (carry_o == ({1'b0, a_i} >= need))
        else $error("subtract carry mismatch");
    if (subtract_i)
      p_sub_ovf_r4: assert (ovf_o == ((a_i[W-1] != b_i[W-1]) && (plain_diff[W-1] != a_i[W-1])))
        else $error("subtract overflow mismatch");
    if (!decimal_i)
      p_bin_zn_r5: assert (zero_o == (sum_o == '0) && neg_o == sum_o[W-1])
        else $error("binary zero/negative mismatch");
    if (decimal_i && !subtract_i)
      p_dec_add_zero_r7: assert (zero_o == (plain_sum[W-1:0] == '0))
        else $error("decimal add zero mismatch");
    if (decimal_i && subtract_i)
      p_dec_sub_zn_r11: assert (zero_o == (plain_diff[W-1:0] == '0) && neg_o == plain_diff[W-1])
        else $error("decimal subtract zero/negative mismatch");
  end
endmodule

bind addsub_unit addsub_checker #(.W(W)) u_addsub_checker (
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_i   (carry_i),
  .decimal_i (decimal_i),
  .subtract_i(subtract_i),
  .sum_o     (sum_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .zero_o    (zero_o),
  .neg_o     (neg_o)
);

// File: tb/test_addsub_unit.sv
module test_addsub_unit;
  logic       clk;
  logic [7:0] a, b;
  logic       cin, dec, sub;
  logic [7:0] sum;
  logic       cout, ovf, zero, neg;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  addsub_unit i_addsub_unit (
    .a_i(a), .b_i(b), .carry_i(cin), .decimal_i(dec), .subtract_i(sub),
    .sum_o(sum), .carry_o(cout), .ovf_o(ovf), .zero_o(zero), .neg_o(neg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 200000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish (got %0d cycles, expected fewer)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic string req_of(input bit d, input bit s, input int field);
    case (field)
      0: return d ? (s ? "R10" : "R6") : (s ? "R12" : "R1");
      1: return s ? "R3" : (d ? "R9" : "R1");
      2: return s ? "R4" : (d ? "R8" : "R2");
      3: return d ? (s ? "R11" : "R7") : "R5";
      default: return d ? (s ? "R11" : "R8") : "R5";
    endcase
  endfunction

  // Behavioural model on integers; returns {res, c, v, z, n}
  function automatic logic [11:0] model(input int ia, input int ib, input int ic,
                                        input bit d, input bit s);
    int r, t, al, ah;
    bit c, v, z, n;
    if (!s) begin
      t = ia + ib + ic;
      if (!d) begin
        r = t & 255;
        c = (t > 255);
        v = (((ia ^ ib) & 128) == 0) && (((ia ^ t) & 128) != 0);
        z = (r == 0);
        n = (r & 128) != 0;
      end else begin
        al = (ia & 15) + (ib & 15) + ic;
        if (al > 9) al = al + 6;
        ah = (ia >> 4) + (ib >> 4);
        if (al > 15) ah = ah + 1;
        z = ((t & 255) == 0);
        n = (ah & 8) != 0;
        v = ((((ah << 4) ^ ia) & 128) != 0) && (((ia ^ ib) & 128) == 0);
        if (ah > 9) ah = ah + 6;
        c = (ah > 15);
        r = ((ah << 4) | (al & 15)) & 255;
      end
    end else begin
      t = ia - ib - (1 - ic);
      c = (t >= 0);
      v = (((ia ^ t) & 128) != 0) && (((ia ^ ib) & 128) != 0);
      z = ((t & 255) == 0);
      n = (t & 128) != 0;
      if (!d) begin
        r = t & 255;
      end else begin
        al = (ia & 15) - (ib & 15) - (1 - ic);
        ah = (ia >> 4) - (ib >> 4);
        if ((al & 16) != 0) begin
          al = al - 6;
          ah = ah - 1;
        end
        if ((ah & 16) != 0) ah = ah - 6;
        r = ((ah << 4) | (al & 15)) & 255;
      end
    end
    return {r[7:0], c, v, z, n};
  endfunction

  task automatic compare(input logic [11:0] exp);
    logic [11:0] got;
    got = {sum, cout, ovf, zero, neg};
    checks++;
    if (got[11:4] !== exp[11:4]) begin
      fails++;
      $display("FAIL %s result a=%h b=%h c=%b d=%b s=%b: got %h expected %h",
               req_of(dec, sub, 0), a, b, cin, dec, sub, got[11:4], exp[11:4]);
    end
    for (int f = 1; f < 5; f++) begin
      checks++;
      if (got[4-f] !== exp[4-f]) begin
        fails++;
        $display("FAIL %s flag%0d a=%h b=%h c=%b d=%b s=%b: got %b expected %b",
                 req_of(dec, sub, f), f, a, b, cin, dec, sub, got[4-f], exp[4-f]);
      end
    end
  endtask

  task automatic apply(input int ia, input int ib, input bit ic, input bit d, input bit s);
    a = ia[7:0]; b = ib[7:0]; cin = ic; dec = d; sub = s;
    #1;
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; dec = 1'b0; sub = 1'b0;
    #3;
    // R9 R7 R8: 0x99+0x01 decimal -> 00, C1 V0 Z0 N1
    apply(8'h99, 8'h01, 1'b0, 1'b1, 1'b0);
    compare({8'h00, 1'b1, 1'b0, 1'b0, 1'b1});
    // R10 R11 R3: 0x00-0x01 decimal, carry set -> 99, C0 V0 Z0 N1
    apply(8'h00, 8'h01, 1'b1, 1'b1, 1'b1);
    compare({8'h99, 1'b0, 1'b0, 1'b0, 1'b1});
    // R2 R5: 0x50+0x50 binary -> A0, C0 V1 Z0 N1
    apply(8'h50, 8'h50, 1'b0, 1'b0, 1'b0);
    compare({8'hA0, 1'b0, 1'b1, 1'b0, 1'b1});
    // R8 R9: 0x50+0x50 decimal -> 00, C1 V1 Z0 N1
    apply(8'h50, 8'h50, 1'b0, 1'b1, 1'b0);
    compare({8'h00, 1'b1, 1'b1, 1'b0, 1'b1});
    // R12 R4: 0x80-0x01 binary, carry set -> 7F, C1 V1 Z0 N0
    apply(8'h80, 8'h01, 1'b1, 1'b0, 1'b1);
    compare({8'h7F, 1'b1, 1'b1, 1'b0, 1'b0});
    // R1 R5: 0xFF+0x00+1 binary -> 00, C1 V0 Z1 N0
    apply(8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
    compare({8'h00, 1'b1, 1'b0, 1'b1, 1'b0});
    // R1..R12 exhaustive sweep
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int ia = 0; ia < 256; ia++)
          for (int ib = 0; ib < 256; ib++) begin
            apply(ia, ib, c[0], m[1], m[0]);
            compare(model(ia, ib, c, m[1], m[0]));
          end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule